// File: doc/BRIEF.md
# Modem Control and Status Unit

This block holds the modem-control byte and the modem-status byte of a 16550-style serial port. It drives four control outputs (data-terminal-ready, request-to-send and two general-purpose auxiliary outputs) from the control byte. It watches four incoming modem lines (clear-to-send, data-set-ready, ring indicator and carrier detect). Each change on a line is recorded in a sticky delta bit. The delta bits stay set until software reads the status byte.

The incoming lines pass through a synchroniser before any edge is detected. A loopback bit in the control byte disconnects the external lines. In loopback the status bits are fed from the control bits instead, so software can test the delta logic without a modem attached. A single interrupt-request output goes high whenever any delta bit is set. Priority against other interrupt sources is left to the surrounding port.

Register access uses one select bit. `reg_sel` = 0 picks the control byte and `reg_sel` = 1 picks the status byte. `rd_data` always shows the selected byte. The `reg_rd` strobe is what marks a read that has a side effect. `reg_wr` with `reg_sel` = 0 writes the control byte. A write with `reg_sel` = 1 is ignored.

Top module: `mdm_status_ctl`

## Requirements
- R1: After reset the status byte reads 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no deltas). The control byte reads 0x08. `modem_irq` is low, `out_aux2` is high, and the other control outputs and `loop_mode` are low.
- R2: The control byte keeps only write bits 4:0: bit0 data-terminal-ready, bit1 request-to-send, bit2 aux1, bit3 aux2, bit4 loopback. Bits 7:5 read back as zero. Outside loopback, `out_dtr`, `out_rts`, `out_aux1` and `out_aux2` follow bits 0 to 3.
- R3: Status bits 7:4 are carrier, ring, data-set-ready and clear-to-send, in that order. A change on an input pin appears there on the third rising edge after the pin changes, and not earlier (two synchroniser stages plus the status register).
- R4: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier) each become set when their line changes in either direction.
- R5: Status bit 2 becomes set only when the ring line falls from 1 to 0. A rising ring line leaves it clear.
- R6: Delta bits accumulate. Once set, a bit stays set until the status byte is read, whatever the lines do afterwards.
- R7: A status read with `reg_rd` high returns the byte as it was before the read. All four delta bits are cleared at that clock edge. A line change that lands at the same edge is kept as a new delta.
- R8: `modem_irq` is high exactly when at least one of the four delta bits is set.
- R9: In loopback the status lines take their values from the control bits: aux2 drives carrier, aux1 drives ring, request-to-send drives clear-to-send, and data-terminal-ready drives data-set-ready. These values appear two edges after the write.
- R10: In loopback `out_rts` and `out_dtr` are held low and `loop_mode` is high. Changes on the external input pins have no effect on the status byte.
- R11: Reading the control byte leaves the delta bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects the control byte, 1 selects the status byte |
| reg_wr | input | 1 | Write strobe; writes the control byte when `reg_sel` = 0 |
| reg_rd | input | 1 | Read strobe; a status read clears the deltas |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected register, combinational |
| in_cts | input | 1 | Clear-to-send line, active high |
| in_dsr | input | 1 | Data-set-ready line, active high |
| in_ri | input | 1 | Ring-indicator line, active high |
| in_dcd | input | 1 | Carrier-detect line, active high |
| out_dtr | output | 1 | Data-terminal-ready output |
| out_rts | output | 1 | Request-to-send output |
| out_aux1 | output | 1 | General-purpose output 1 |
| out_aux2 | output | 1 | General-purpose output 2 |
| loop_mode | output | 1 | Loopback active |
| modem_irq | output | 1 | Any delta bit set |

## Verification
The bench builds the block with its default two-stage synchroniser. The input-to-status latency is therefore a fixed three edges, and the bench checks it on exactly those edges. With only four lines there are 256 ordered pairs of line states. The bench sweeps every pair and checks the expected delta nibble and interrupt for each one. The same small width lets it walk all sixteen loopback control patterns and all sixteen direct-drive patterns. The read-versus-change collision at a single edge is also checked.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int LINE_W = 4;
    localparam int CTRL_W = 5;
    localparam int BYTE_W = 8;

    // Status line order matches status byte bits 7:4
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    // Control order matches control byte bits 4:0
    typedef struct packed {
        logic loop_en;
        logic aux2;
        logic aux1;
        logic rts;
        logic dtr;
    } mdm_ctrl_t;

    localparam mdm_lines_t LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
    localparam mdm_ctrl_t  CTRL_RST  = '{loop_en: 1'b0, aux2: 1'b1, aux1: 1'b0,
                                         rts: 1'b0, dtr: 1'b0};

    // Lines seen by the status logic when outputs are folded back
    function automatic mdm_lines_t loop_lines(input mdm_ctrl_t c);
        mdm_lines_t l;
        l.dcd = c.aux2;
        l.ri  = c.aux1;
        l.dsr = c.dtr;
        l.cts = c.rts;
        return l;
    endfunction

    // Change flags: {carrier, ring falling, data-set-ready, clear-to-send}
    function automatic logic [LINE_W-1:0] change_of(input mdm_lines_t prev,
                                                    input mdm_lines_t next);
        logic [LINE_W-1:0] d;
        d[3] = prev.dcd ^ next.dcd;
        d[2] = prev.ri & ~next.ri;
        d[1] = prev.dsr ^ next.dsr;
        d[0] = prev.cts ^ next.cts;
        return d;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output mdm_ctrl_t         ctrl_q
);
    logic unused_hi;
    assign unused_hi = ^wr_data[BYTE_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= CTRL_RST;
        else if (wr_en) ctrl_q <= mdm_ctrl_t'(wr_data[CTRL_W-1:0]);
    end
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mdm_lines_t        lines_in,
    input  logic              clr,
    output mdm_lines_t        lvl_q,
    output logic [LINE_W-1:0] delta_q
);
    logic [LINE_W-1:0] delta_kept;

    assign delta_kept = clr ? '0 : delta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= LINES_RST;
            delta_q <= '0;
        end else begin
            lvl_q   <= lines_in;
            delta_q <= delta_kept | change_of(lvl_q, lines_in);
        end
    end
endmodule

// File: rtl/mdm_status_ctl.sv
module mdm_status_ctl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       in_cts,
    input  logic       in_dsr,
    input  logic       in_ri,
    input  logic       in_dcd,
    output logic       out_dtr,
    output logic       out_rts,
    output logic       out_aux1,
    output logic       out_aux2,
    output logic       loop_mode,
    output logic       modem_irq
);
    mdm_ctrl_t         ctrl_q;
    mdm_lines_t        pins_raw;
    logic [LINE_W-1:0] pins_sync;
    mdm_lines_t        lines_sel;
    mdm_lines_t        lvl_q;
    logic [LINE_W-1:0] delta_q;
    logic [BYTE_W-1:0] status_q;

    assign pins_raw = '{dcd: in_dcd, ri: in_ri, dsr: in_dsr, cts: in_cts};

    mdm_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr & ~reg_sel),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    mdm_sync #(
        .WIDTH   (LINE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINES_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_sync)
    );

    assign lines_sel = ctrl_q.loop_en ? loop_lines(ctrl_q) : mdm_lines_t'(pins_sync);

    mdm_delta u_delta (
        .clk      (clk),
        .rst      (rst),
        .lines_in (lines_sel),
        .clr      (reg_rd & reg_sel),
        .lvl_q    (lvl_q),
        .delta_q  (delta_q)
    );

    assign status_q  = {lvl_q, delta_q};
    assign rd_data   = reg_sel ? status_q : {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
    assign out_dtr   = ctrl_q.dtr & ~ctrl_q.loop_en;
    assign out_rts   = ctrl_q.rts & ~ctrl_q.loop_en;
    assign out_aux1  = ctrl_q.aux1;
    assign out_aux2  = ctrl_q.aux2;
    assign loop_mode = ctrl_q.loop_en;
    assign modem_irq = |delta_q;
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_sel,
    input logic       reg_rd,
    input logic [7:0] rd_data,
    input logic [7:0] status_q,
    input logic       modem_irq,
    input logic       loop_mode,
    input logic       out_rts,
    input logic       out_dtr
);
    p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_sel) |-> (rd_data[7:5] == 3'b000));

    p_cts_delta_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[0]) |-> (status_q[4] != $past(status_q[4])));

    p_ring_fall_only_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[2]) |-> $fell(status_q[6]));

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (modem_irq && !(reg_rd && reg_sel)) |=> modem_irq);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel) |=>
            ((status_q[7:4] != $past(status_q[7:4])) || (status_q[3:0] == 4'b0000)));

    p_loop_pins_low_r10: assert property (@(posedge clk) disable iff (rst)
        loop_mode |-> (!out_rts && !out_dtr));
endmodule

bind mdm_status_ctl mdm_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_rd    (reg_rd),
    .rd_data   (rd_data),
    .status_q  (status_q),
    .modem_irq (modem_irq),
    .loop_mode (loop_mode),
    .out_rts   (out_rts),
    .out_dtr   (out_dtr)
);

// File: tb/tb_mdm_status_ctl.sv
module tb_mdm_status_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] pins = 4'b1011;   // {dcd, ri, dsr, cts}
    logic       out_dtr, out_rts, out_aux1, out_aux2, loop_mode, modem_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mdm_status_ctl dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .wr_data(wr_data), .rd_data(rd_data),
        .in_cts(pins[0]), .in_dsr(pins[1]), .in_ri(pins[2]), .in_dcd(pins[3]),
        .out_dtr(out_dtr), .out_rts(out_rts), .out_aux1(out_aux1), .out_aux2(out_aux2),
        .loop_mode(loop_mode), .modem_irq(modem_irq)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b1; wr_data = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #2 v = rd_data;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [3:0] exp_delta(input logic [3:0] a, input logic [3:0] b);
        return {a[3] ^ b[3], a[2] & ~b[2], a[1] ^ b[1], a[0] ^ b[0]};
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(1'b1, v); chk(v, 8'hB0, "R1 status");
        rd_reg(1'b0, v); chk(v, 8'h08, "R1 control");
        chk({3'b0, modem_irq, loop_mode, out_aux2, out_aux1, out_rts | out_dtr},
            8'h04, "R1 pins");

        // R2 write masking and direct drive
        wr_ctrl(8'hEF);
        rd_reg(1'b0, v); chk(v, 8'h0F, "R2 mask");
        for (int c = 0; c < 16; c++) begin
            wr_ctrl(8'hE0 | 8'(c));
            #2 chk({4'b0, out_aux2, out_aux1, out_rts, out_dtr}, 8'(c), "R2 drive");
        end
        wr_ctrl(8'h08);
        rd_reg(1'b1, v);

        // R3 exact latency: cts 1->0
        @(negedge clk); pins = 4'b1010; reg_sel = 1'b1;
        @(negedge clk); @(negedge clk);
        #2 chk(rd_data, 8'hB0, "R3 not before third edge");
        @(negedge clk);
        #2 chk(rd_data, 8'hA1, "R3 at third edge");
        rd_reg(1'b1, v);

        // R4 R5 R8 R3: every ordered pair of line states
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                @(negedge clk); pins = 4'(a);
                repeat (3) @(negedge clk);
                rd_reg(1'b1, v);
                @(negedge clk); pins = 4'(b);
                repeat (3) @(negedge clk);
                #2 chk({7'b0, modem_irq}, {7'b0, exp_delta(4'(a), 4'(b)) != 4'b0}, "R8 irq");
                rd_reg(1'b1, v);
                chk(v, {4'(b), exp_delta(4'(a), 4'(b))}, "R4 R5 sweep");
            end
        end

        // R6 accumulate: dcd falls, then rises back; ring rises
        @(negedge clk); pins = 4'b1011;
        repeat (4) @(negedge clk); rd_reg(1'b1, v);
        @(negedge clk); pins = 4'b0011;
        repeat (4) @(negedge clk);
        @(negedge clk); pins = 4'b1111;
        repeat (4) @(negedge clk);
        // R11 control read leaves deltas alone
        rd_reg(1'b0, v);
        rd_reg(1'b1, v); chk(v, 8'hF8, "R6 R11 sticky");
        rd_reg(1'b1, v); chk(v, 8'hF0, "R7 cleared");

        // R7 change landing on the read edge is kept
        @(negedge clk); pins = 4'b1110;
        @(negedge clk); @(negedge clk);
        reg_sel = 1'b1; reg_rd = 1'b1;
        #2 chk(rd_data, 8'hF0, "R7 old value");
        @(negedge clk); reg_rd = 1'b0;
        #2 chk(rd_data, 8'hE1, "R7 new delta kept");
        rd_reg(1'b1, v);

        // R9 R10 loopback sweep
        for (int c = 0; c < 16; c++) begin
            wr_ctrl(8'h10 | 8'(c));
            @(negedge clk);
            rd_reg(1'b1, v);
            chk({4'b0, v[7:4]}, {4'b0, c[3], c[2], c[0], c[1]}, "R9 loop map");
            chk({5'b0, loop_mode, out_rts, out_dtr}, 8'h04, "R10 pins");
        end
        rd_reg(1'b1, v);
        @(negedge clk); pins = ~pins;
        repeat (5) @(negedge clk);
        rd_reg(1'b1, v); chk(v, 8'hF0, "R10 ignore ext");
        wr_ctrl(8'h08);
        repeat (4) @(negedge clk);
        rd_reg(1'b1, v);
        rd_reg(1'b1, v); chk(v, {pins, 4'b0}, "R10 ext restored");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule